// File: doc/BRIEF.md
# DRAM Power-Up and CAS-Before-RAS Refresh Sequencer

This block brings an asynchronous DRAM from power-up to a usable state and then keeps every row refreshed. After reset it holds all strobes inactive for a long settling pause. It then fires a fixed burst of CAS-before-RAS refresh cycles back to back, which primes the DRAM's own row counter, and only then raises `ready`. From that point an interval timer marks each refresh slot. The block keeps a small count of slots still owed to the DRAM.

The RAS, CAS and WE pins are shared with an access controller. While refresh slots are owed and no refresh cycle is running, the sequencer raises `ref_req`. The controller answers with `ref_gnt` once its own access has finished. The sequencer then owns the pins and signals this with `ref_busy` until the cycle ends. When the owed count reaches its limit, `ref_urgent` tells the controller to grant right after its current access.

Every refresh cycle has four parts, in this order:
- a short precharge with both strobes high;
- CAS low while RAS is still high;
- both strobes low;
- a RAS precharge with both strobes high.

Both byte-lane CAS pins move together. WE and OE stay high, so the data bus is never driven.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low, `ready`, `ref_req`, `ref_busy` and `ref_urgent` are 0, and `ras_n`, `ucas_n` and `lcas_n` are 1.
- R2: After reset is released, no strobe goes low during the first `PAUSE_CYC` clock cycles.
- R3: After the pause, exactly `INIT_REFRESHES` refresh cycles are issued before `ready` rises. `ref_req` stays 0 while `ready` is 0. Once `ready` is 1 it stays 1 until reset.
- R4: In each refresh cycle, CAS (active low) falls while RAS is high and stays low alone for `CSR_CYC` cycles. RAS is then low for exactly `RAS_CYC` cycles, with CAS low throughout. CAS and RAS rise on the same edge. Strobes are low only while `ref_busy` is 1.
- R5: `ref_busy` rises `PRE_CYC` cycles before CAS falls. It stays high for `PRE_CYC+CSR_CYC+RAS_CYC+RP_CYC` cycles in total, so RAS is high for `RP_CYC` cycles after each cycle.
- R6: `ucas_n` always equals `lcas_n`, and `we_n` and `oe_n` are always 1.
- R7: Once `ready` is 1, one refresh slot is owed every `INTERVAL_CYC` cycles; the first comes `INTERVAL_CYC` cycles after `ready` rises. `ref_req` is 1 exactly when at least one slot is owed and `ref_busy` is 0.
- R8: `ref_req` and `ref_gnt` both high at an edge starts a cycle. In the next cycle `ref_busy` is 1, and the owed count is one lower.
- R9: The interval timer keeps running while a request waits. A slot that falls due on the same edge as a grant leaves the owed count unchanged.
- R10: The owed count saturates at `PEND_MAX`. `ref_urgent` is 1 exactly when the count equals `PEND_MAX`.
- R11: `ref_gnt` while `ref_req` is 0 has no effect: no cycle starts and the owed count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Access controller hands the pins over |
| ref_req | output | 1 | A refresh slot is owed and the sequencer is idle |
| ref_urgent | output | 1 | Owed count at its limit |
| ref_busy | output | 1 | Sequencer is driving the DRAM pins |
| ready | output | 1 | Initialisation finished |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper column strobe, active low |
| lcas_n | output | 1 | Lower column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |

## Verification
A new slot falling due and a grant being taken can land on the same clock edge. The owed counter must then add and subtract at once. One bench phase raises the grant only in the cycle before each timer expiry, so every accepted grant meets a new slot. The owed count, read through `ref_req` and `ref_urgent`, must then stay flat across the whole phase. Saturation is reached first by withholding grants for several intervals. A model of the owed count and the busy window in the bench judges every cycle.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [1:0] {
        SEQ_PAUSE,
        SEQ_BURST,
        SEQ_RUN
    } seq_state_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_CSU,
        PH_ACT,
        PH_RP
    } cyc_phase_e;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL_CYC);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    assign tick = en && (q.cnt == LAST);

    always_comb begin
        d = q;
        if (!en || tick) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
    parameter int PEND_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic take,
    output logic owed,
    output logic full
);
    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] TOP = PW'(PEND_MAX);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } blog_t;

    blog_t q, d;

    assign owed = (q.cnt != '0);
    assign full = (q.cnt == TOP);

    always_comb begin
        d = q;
        unique case ({add, take})
            2'b10:   if (q.cnt != TOP) d.cnt = q.cnt + 1'b1;
            2'b01:   if (q.cnt != '0)  d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cbr_cycle_engine.sv
module cbr_cycle_engine
    import dram_refresh_pkg::*;
#(
    parameter int PRE_CYC = 1,
    parameter int CSR_CYC = 1,
    parameter int RAS_CYC = 6,
    parameter int RP_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic ras_n,
    output logic cas_n
);
    localparam int M1   = (PRE_CYC > CSR_CYC) ? PRE_CYC : CSR_CYC;
    localparam int M2   = (RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        cyc_phase_e     ph;
        logic [CW-1:0]  left;
        logic           ras_n;
        logic           cas_n;
    } eng_t;

    eng_t q, d;

    assign busy  = (q.ph != PH_IDLE);
    assign ras_n = q.ras_n;
    assign cas_n = q.cas_n;

    always_comb begin
        d = q;
        unique case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph   = PH_PRE;
                    d.left = CW'(PRE_CYC - 1);
                end
            end
            PH_PRE: begin
                if (q.left == '0) begin
                    d.ph   = PH_CSU;
                    d.left = CW'(CSR_CYC - 1);
                end else begin
                    d.left = q.left - 1'b1;
                end
            end
            PH_CSU: begin
                if (q.left == '0) begin
                    d.ph   = PH_ACT;
                    d.left = CW'(RAS_CYC - 1);
                end else begin
                    d.left = q.left - 1'b1;
                end
            end
            PH_ACT: begin
                if (q.left == '0) begin
                    d.ph   = PH_RP;
                    d.left = CW'(RP_CYC - 1);
                end else begin
                    d.left = q.left - 1'b1;
                end
            end
            PH_RP: begin
                if (q.left == '0) begin
                    d.ph   = PH_IDLE;
                    d.left = '0;
                end else begin
                    d.left = q.left - 1'b1;
                end
            end
            default: begin
                d.ph   = PH_IDLE;
                d.left = '0;
            end
        endcase
        // strobes are registered from the next phase so the pins never glitch
        d.ras_n = (d.ph != PH_ACT);
        d.cas_n = !((d.ph == PH_CSU) || (d.ph == PH_ACT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ph    <= PH_IDLE;
            q.left  <= '0;
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_refresh_pkg::*;
#(
    parameter int PAUSE_CYC      = 20000,
    parameter int INIT_REFRESHES = 8,
    parameter int INTERVAL_CYC   = 1560,
    parameter int PEND_MAX       = 4,
    parameter int PRE_CYC        = 1,
    parameter int CSR_CYC        = 1,
    parameter int RAS_CYC        = 6,
    parameter int RP_CYC         = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_urgent,
    output logic ref_busy,
    output logic ready,
    output logic ras_n,
    output logic ucas_n,
    output logic lcas_n,
    output logic we_n,
    output logic oe_n
);
    localparam int PCW = $clog2(PAUSE_CYC);
    localparam int ICW = $clog2(INIT_REFRESHES + 1);
    localparam logic [PCW-1:0] PAUSE_LAST = PCW'(PAUSE_CYC - 1);
    localparam logic [ICW-1:0] BURST_N    = ICW'(INIT_REFRESHES);

    typedef struct packed {
        seq_state_e     st;
        logic [PCW-1:0] pause;
        logic [ICW-1:0] issued;
        logic           ready;
    } seq_t;

    seq_t q, d;

    logic eng_start;
    logic eng_busy;
    logic eng_ras_n;
    logic eng_cas_n;
    logic slot_tick;
    logic slot_owed;
    logic slot_full;

    refresh_interval_timer #(
        .INTERVAL_CYC (INTERVAL_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.ready),
        .tick  (slot_tick)
    );

    refresh_backlog #(
        .PEND_MAX (PEND_MAX)
    ) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .add   (slot_tick),
        .take  (eng_start && q.ready),
        .owed  (slot_owed),
        .full  (slot_full)
    );

    cbr_cycle_engine #(
        .PRE_CYC (PRE_CYC),
        .CSR_CYC (CSR_CYC),
        .RAS_CYC (RAS_CYC),
        .RP_CYC  (RP_CYC)
    ) u_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .busy  (eng_busy),
        .ras_n (eng_ras_n),
        .cas_n (eng_cas_n)
    );

    assign ref_req    = q.ready && slot_owed && !eng_busy;
    assign ref_urgent = q.ready && slot_full;
    assign ref_busy   = eng_busy;
    assign ready      = q.ready;
    assign ras_n      = eng_ras_n;
    assign ucas_n     = eng_cas_n;
    assign lcas_n     = eng_cas_n;
    assign we_n       = 1'b1;
    assign oe_n       = 1'b1;

    always_comb begin
        d         = q;
        eng_start = 1'b0;
        unique case (q.st)
            SEQ_PAUSE: begin
                if (q.pause == PAUSE_LAST) begin
                    d.st = SEQ_BURST;
                end else begin
                    d.pause = q.pause + 1'b1;
                end
            end
            SEQ_BURST: begin
                if (!eng_busy) begin
                    if (q.issued != BURST_N) begin
                        eng_start = 1'b1;
                        d.issued  = q.issued + 1'b1;
                    end else begin
                        d.st = SEQ_RUN;
                    end
                end
            end
            SEQ_RUN: begin
                eng_start = ref_req && ref_gnt;
            end
            default: d.st = SEQ_PAUSE;
        endcase
        d.ready = (d.st == SEQ_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= SEQ_PAUSE;
            q.pause  <= '0;
            q.issued <= '0;
            q.ready  <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_gnt,
    input logic ref_req,
    input logic ref_urgent,
    input logic ref_busy,
    input logic ready,
    input logic ras_n,
    input logic ucas_n,
    input logic lcas_n
);
    a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!ucas_n && $past(!ucas_n)));

    a_r4_cas_rises_with_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> $rose(ucas_n));

    a_r4_strobes_need_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!ucas_n || !ras_n) |-> ref_busy);

    a_r6_cas_lanes_equal: assert property (@(posedge clk) disable iff (!rst_n)
        ucas_n == lcas_n);

    a_r3_no_req_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !ref_req);

    a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    a_r8_grant_launches: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> (ref_busy && !ref_req));

    a_r10_urgent_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_urgent && !ref_busy) |-> ref_req);

    a_r11_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !ref_req && !ref_busy) |=> !ref_busy);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .ref_busy   (ref_busy),
    .ready      (ready),
    .ras_n      (ras_n),
    .ucas_n     (ucas_n),
    .lcas_n     (lcas_n)
);

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;
    localparam int PAUSE   = 60;
    localparam int NINIT   = 8;
    localparam int INTV    = 30;
    localparam int PMAX    = 3;
    localparam int PRE     = 1;
    localparam int CSR     = 2;
    localparam int RASC    = 4;
    localparam int RP      = 2;
    localparam int CYCLEN  = PRE + CSR + RASC + RP;
    localparam int RUN_LEN = 1300;

    logic clk = 1'b0;
    logic rst_n;
    logic ref_gnt;
    logic ref_req, ref_urgent, ref_busy, ready;
    logic ras_n, ucas_n, lcas_n, we_n, oe_n;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC (PAUSE), .INIT_REFRESHES (NINIT), .INTERVAL_CYC (INTV),
        .PEND_MAX (PMAX), .PRE_CYC (PRE), .CSR_CYC (CSR), .RAS_CYC (RASC), .RP_CYC (RP)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ref_gnt (ref_gnt), .ref_req (ref_req),
        .ref_urgent (ref_urgent), .ref_busy (ref_busy), .ready (ready),
        .ras_n (ras_n), .ucas_n (ucas_n), .lcas_n (lcas_n), .we_n (we_n), .oe_n (oe_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clamp_pend(input int v);
        return (v > PMAX) ? PMAX : v;
    endfunction

    function automatic bit grant_policy(input int s);
        if (s < 150)  return 1'b0;                          // let owed slots pile up
        if (s < 700)  return ($urandom_range(0, 2) == 0);   // random grants
        if (s < 1100) return ((s + 1) % INTV == 0);         // grant meets the tick
        return 1'b1;                                        // grant held high
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int  idx = 0, s = 0, ras_falls = 0;
        int  cnt_busy = 0, cnt_csr = 0, cnt_act = 0;
        int  exp_pend = 0, busy_left = 0;
        bit  seen_ready = 0, first_cas = 0, exp_req = 0, gnt_prev = 0, req_prev = 0;
        logic p_ras = 1, p_cas = 1, p_busy = 0;
        void'($urandom(32'h1357));
        rst_n   = 1'b0;
        ref_gnt = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!ready && !ref_req && !ref_busy && !ref_urgent, "R1 flags", {ready, ref_req, ref_busy, ref_urgent}, 0);
        chk(ras_n && ucas_n && lcas_n, "R1 strobes", {ras_n, ucas_n, lcas_n}, 7);
        rst_n = 1'b1;
        while (s < RUN_LEN) begin
            @(negedge clk);
            idx++;
            // ---- strobe shape monitors (R4, R5, R6)
            if (ref_busy && !p_busy) cnt_busy = 1;
            else if (ref_busy)       cnt_busy++;
            if (!ref_busy && p_busy) chk(cnt_busy == CYCLEN, "R5 busy length", cnt_busy, CYCLEN);
            if (!ucas_n && p_cas) begin
                chk(ras_n, "R4 ras high at cas fall", ras_n, 1);
                chk(cnt_busy == PRE + 1, "R5 precharge before cas", cnt_busy - 1, PRE);
                if (!first_cas) begin
                    first_cas = 1;
                    chk(idx > PAUSE, "R2 pause honoured", idx, PAUSE + 1);
                end
                cnt_csr = 1;
            end else if (!ucas_n && ras_n) cnt_csr++;
            if (!ras_n && p_ras) begin
                chk(cnt_csr == CSR, "R4 cas lead", cnt_csr, CSR);
                cnt_act = 1;
                if (!seen_ready) ras_falls++;
            end else if (!ras_n) cnt_act++;
            if (ras_n && !p_ras) begin
                chk(cnt_act == RASC, "R4 ras low width", cnt_act, RASC);
                chk(ucas_n, "R4 cas rises with ras", ucas_n, 1);
            end
            if (!ras_n || !ucas_n) chk(ref_busy, "R4 strobe outside busy", ref_busy, 1);
            if (ucas_n != lcas_n || !we_n || !oe_n)
                chk(1'b0, "R6 lanes/we/oe", {ucas_n, lcas_n, we_n, oe_n}, 4'b0011);
            p_ras = ras_n; p_cas = ucas_n; p_busy = ref_busy;
            // ---- initialisation and run phase
            if (!seen_ready) begin
                if (ref_req) chk(1'b0, "R3 req before ready", ref_req, 0);
                if (ready) begin
                    seen_ready = 1;
                    s = 0;
                    chk(ras_falls == NINIT, "R3 burst count", ras_falls, NINIT);
                    chk(!ref_busy, "R3 idle at ready", ref_busy, 0);
                end
            end else begin
                bit    tick, started;
                string tag;
                s++;
                chk(ready, "R3 ready sticky", ready, 1);
                tick    = (s % INTV == 0);
                started = gnt_prev && req_prev;
                exp_pend = clamp_pend(exp_pend + int'(tick) - int'(started));
                if (started) busy_left = CYCLEN;
                exp_req = (exp_pend > 0) && (busy_left == 0);
                tag = (tick && started) ? "R9 tick with grant" :
                      (gnt_prev && !req_prev) ? "R11 grant ignored" : "R8 grant start";
                chk(ref_busy == (busy_left > 0), tag, ref_busy, int'(busy_left > 0));
                chk(ref_req == exp_req, (tick && started) ? "R9 req" : "R7 req", ref_req, exp_req);
                chk(ref_urgent == (exp_pend == PMAX), "R10 urgent", ref_urgent, int'(exp_pend == PMAX));
                if (busy_left > 0) busy_left--;
            end
            req_prev = exp_req;
            gnt_prev = seen_ready ? grant_policy(s) : 1'b0;
            ref_gnt  = gnt_prev;
            if (idx > 20000) begin
                chk(1'b0, "R3 ready never rose", 0, 1);
                break;
            end
        end
        finish_run();
    end
endmodule